// File: doc/BRIEF.md
# I2C master byte receiver with clock stall

This block is the receive half of an I2C master, taking over once the slave address has gone out. Software leaves transmit mode by clearing the transmit/receive select. It then performs one read of the receive data register while the engine is idle, and that read starts the first frame. The engine generates SCL from the system clock and shifts in eight data bits, most significant first. On the ninth clock pulse it drives the programmed acknowledge level onto SDA.

Each completed byte raises a receive-full flag, and reading the data register clears it. If software has not collected the previous byte when the ninth pulse of the next frame is due, the engine keeps SCL low until the read arrives. Software requests a stop by setting a last-byte control before reading the byte that precedes the final one. The engine then ends the transfer with a stop condition after that final byte, raises a stop-done flag and returns to idle.

Both bus lines are open-drain. Each is brought out as a pull-low enable and a line input, so a bench or a pad ring can model the wired-AND bus.

Top module: `i2c_rx_master`

## Requirements
- R1: After reset, scl_oe, sda_oe, rx_full, stop_done and last_pend are all 0.
- R2: A pulse on rd_req while idle, with xmit_sel=0 and rx_full=0, pulls SCL low from the next cycle and starts a frame. A pulse on rd_req while xmit_sel=1 leaves SCL released.
- R3: Each SCL low phase and each high phase lasts H system clocks, where H is half_period clamped to a minimum of 2. A frame has nine high pulses, and sda_oe is 0 at the rising edge of each of the first eight.
- R4: SDA is sampled once in each of the first eight high phases, and the first bit sampled becomes bit 7. rd_data then holds the byte that the slave drove.
- R5: sda_oe equals the inverse of ack_bit at the ninth rising edge of SCL (ack_bit 0 gives ACK with SDA pulled low, 1 gives NACK with SDA released).
- R6: rx_full becomes 1 on the clock edge at which SCL is released for the ninth pulse, and rd_data is loaded on the same edge. A read clears rx_full on the following edge. When a read and a new byte fall on the same edge, rx_full stays 1.
- R7: If rx_full is still 1 when the low phase before the ninth pulse has run its H clocks, SCL stays low until a read. SCL is released on the clock edge that samples that read.
- R8: When the last-byte control is not armed, the next frame starts right after the ninth pulse falls, with no stop in between.
- R9: last_req sets last_pend. A read made while last_pend is 1, including the starting dummy read, makes the final byte the first one whose ninth rising edge comes on or after that read.
- R10: After the final byte, SDA is pulled low while SCL is low for H clocks. SCL is then released, and SDA is released H clocks later. At that point stop_done becomes 1, last_pend becomes 0 and the engine is idle.
- R11: A read while idle with rx_full=1 only clears rx_full and does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xmit_sel | input | 1 | Transmit/receive select: 1 = transmit (receive engine idle), 0 = receive |
| ack_bit | input | 1 | Level driven on the ninth pulse: 0 = ACK, 1 = NACK |
| rd_req | input | 1 | One-cycle read of the receive data register |
| last_req | input | 1 | One-cycle set of the last-byte control |
| half_period | input | DIV_W | SCL half period in system clocks (values below 2 act as 2) |
| rd_data | output | DATA_W | Receive data register |
| rx_full | output | 1 | Receive-full flag |
| last_pend | output | 1 | Last-byte control is set |
| stop_done | output | 1 | Stop condition completed; cleared when the next frame starts |
| scl_oe | output | 1 | Pull SCL low |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
The loading of a new byte and a software read that clears rx_full can fall on one clock edge. This happens when a read releases a stalled ninth pulse, because that same edge also sets rx_full. The bench lets a byte go unread until SCL is parked low, checks that no ninth pulse has been seen, and then issues the read together with the last-byte control. On the next sample it requires SCL released, rx_full still 1 and rd_data holding the new byte, while the read itself returned the older byte.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_STOP_LOW,
    ST_STOP_HIGH
  } rx_state_e;

  // Shortest legal half period in system clocks.
  localparam int MIN_HALF = 2;

  function automatic int clamp_half(int h);
    return (h < MIN_HALF) ? MIN_HALF : h;
  endfunction

  // Counter value inside a high phase at which SDA is sampled.
  function automatic int mid_point(int h);
    return clamp_half(h) / 2;
  endfunction

endpackage

// File: rtl/i2c_rx_timer.sv
module i2c_rx_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic [DIV_W-1:0] half,
  output logic             at_end,
  output logic             at_mid
);
  import i2c_rx_pkg::*;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] mid;

  always_comb begin
    lim = DIV_W'(clamp_half(int'(half)) - 1);
    mid = DIV_W'(mid_point(int'(half)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clr)                    cnt_q <= '0;
    else if (!hold && cnt_q != lim)  cnt_q <= cnt_q + 1'b1;
  end

  assign at_end = (cnt_q == lim);
  assign at_mid = (cnt_q == mid);

endmodule

// File: rtl/i2c_rx_shift.sv
module i2c_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (take) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/i2c_rx_master.sv
module i2c_rx_master #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xmit_sel,
  input  logic              ack_bit,
  input  logic              rd_req,
  input  logic              last_req,
  input  logic [DIV_W-1:0]  half_period,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_full,
  output logic              last_pend,
  output logic              stop_done,
  output logic              scl_oe,
  input  logic              scl_in,
  output logic              sda_oe,
  input  logic              sda_in
);
  import i2c_rx_pkg::*;

  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] ACK_IDX = BIT_W'(DATA_W);

  rx_state_e         state_q;
  logic [BIT_W-1:0]  bit_q;
  logic              final_q;
  logic              stop_after_q;
  logic [DATA_W-1:0] shift_q;
  logic              t_end, t_mid;

  // Named internal events.
  logic idle_w, is_ack, start, low_go, high_go, stop_lo_go, stop_hi_go;
  logic rx_set, stall_hold, sample, arm_now, phase_adv, t_hold;

  assign idle_w     = (state_q == ST_IDLE);
  assign is_ack     = (bit_q == ACK_IDX);
  assign start      = idle_w && rd_req && !xmit_sel && !rx_full;
  assign low_go     = (state_q == ST_LOW) && t_end && (!is_ack || !rx_full || rd_req);
  assign stall_hold = (state_q == ST_LOW) && is_ack && t_end && rx_full && !rd_req;
  assign rx_set     = low_go && is_ack;
  assign high_go    = (state_q == ST_HIGH) && t_end && scl_in;
  assign sample     = (state_q == ST_HIGH) && t_mid && scl_in && !is_ack;
  assign stop_lo_go = (state_q == ST_STOP_LOW) && t_end;
  assign stop_hi_go = (state_q == ST_STOP_HIGH) && t_end && scl_in;
  assign arm_now    = rd_req && last_pend;
  assign phase_adv  = start || low_go || high_go || stop_lo_go || stop_hi_go;
  assign t_hold     = ((state_q == ST_HIGH) || (state_q == ST_STOP_HIGH)) && !scl_in;

  i2c_rx_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (phase_adv || idle_w),
    .hold   (t_hold),
    .half   (half_period),
    .at_end (t_end),
    .at_mid (t_mid)
  );

  i2c_rx_shift #(.W(DATA_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (sample),
    .din   (sda_in),
    .q     (shift_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      bit_q        <= '0;
      stop_after_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q      <= ST_LOW;
          bit_q        <= '0;
          stop_after_q <= 1'b0;
        end
        ST_LOW: if (low_go) begin
          state_q <= ST_HIGH;
          if (is_ack) stop_after_q <= final_q || arm_now;
        end
        ST_HIGH: if (high_go) begin
          if (is_ack) begin
            bit_q   <= '0;
            state_q <= stop_after_q ? ST_STOP_LOW : ST_LOW;
          end else begin
            bit_q   <= bit_q + 1'b1;
            state_q <= ST_LOW;
          end
        end
        ST_STOP_LOW:  if (stop_lo_go) state_q <= ST_STOP_HIGH;
        ST_STOP_HIGH: if (stop_hi_go) state_q <= ST_IDLE;
        default:      state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full   <= 1'b0;
      rd_data   <= '0;
      last_pend <= 1'b0;
      final_q   <= 1'b0;
      stop_done <= 1'b0;
    end else begin
      if (rx_set)      rx_full <= 1'b1;
      else if (rd_req) rx_full <= 1'b0;
      if (rx_set) rd_data <= shift_q;
      if (stop_hi_go)    last_pend <= 1'b0;
      else if (last_req) last_pend <= 1'b1;
      if (stop_hi_go)   final_q <= 1'b0;
      else if (arm_now) final_q <= 1'b1;
      if (start)           stop_done <= 1'b0;
      else if (stop_hi_go) stop_done <= 1'b1;
    end
  end

  always_comb begin
    scl_oe = (state_q == ST_LOW) || (state_q == ST_STOP_LOW);
    sda_oe = (((state_q == ST_LOW) || (state_q == ST_HIGH)) && is_ack && !ack_bit)
          || (state_q == ST_STOP_LOW) || (state_q == ST_STOP_HIGH);
  end

endmodule

// File: rtl/i2c_rx_master_chk.sv
module i2c_rx_master_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_req,
  input logic xmit_sel,
  input logic rx_full,
  input logic stop_done,
  input logic scl_oe,
  input logic sda_oe,
  input logic rx_set,
  input logic stall_hold,
  input logic idle_w
);
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_set |=> rx_full); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rx_set) |=> !rx_full); // R6
  AST_STALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    stall_hold |=> scl_oe); // R7
  AST_NINTH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_set |=> !scl_oe); // R7
  AST_TX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_w && rd_req && xmit_sel) |=> !scl_oe); // R2
  AST_FULL_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_w && rd_req && rx_full) |=> idle_w); // R11
  AST_STOP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_done) |-> (!scl_oe && !sda_oe)); // R10
endmodule

bind i2c_rx_master i2c_rx_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req     (rd_req),
  .xmit_sel   (xmit_sel),
  .rx_full    (rx_full),
  .stop_done  (stop_done),
  .scl_oe     (scl_oe),
  .sda_oe     (sda_oe),
  .rx_set     (rx_set),
  .stall_hold (stall_hold),
  .idle_w     (idle_w)
);

// File: tb/test_i2c_rx_master.sv
`timescale 1ns/1ps
module test_i2c_rx_master;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       xmit_sel = 1'b0, ack_bit = 1'b0, rd_req = 1'b0, last_req = 1'b0;
  logic [7:0] half_period = 8'd4;
  logic [7:0] rd_data;
  logic       rx_full, last_pend, stop_done, scl_oe, sda_oe;
  logic       sda_drv = 1'b1;
  wire        scl_in = !scl_oe;
  wire        sda_in = !sda_oe && sda_drv;

  i2c_rx_master i_i2c_rx_master (
    .clk(clk), .rst_n(rst_n), .xmit_sel(xmit_sel), .ack_bit(ack_bit),
    .rd_req(rd_req), .last_req(last_req), .half_period(half_period),
    .rd_data(rd_data), .rx_full(rx_full), .last_pend(last_pend),
    .stop_done(stop_done), .scl_oe(scl_oe), .scl_in(scl_in),
    .sda_oe(sda_oe), .sda_in(sda_in)
  );

  int total = 0, bad = 0;
  int frames_done = 0, n_exp = 0;
  int k = 0, fidx = 0;
  logic rose = 1'b0, prev_scl = 1'b1, prev_sda_oe = 1'b0;
  logic [7:0] sbytes [4];

  // Vector: [23:16] half period, [15:8] seed, [7:6] byte count - 1, [5] ack_bit, [4:0] read delay / 8
  localparam logic [23:0] VEC [5] = '{24'h04A580, 24'h023C20, 24'h07F0C0, 24'h030174, 24'h018040};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] seed, input int i);
    return seed ^ 8'(i * 59);
  endfunction

  function automatic int eff_half(input int h);
    return (h < 2) ? 2 : h;
  endfunction

  // Slave model, updated away from the active edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      k = 0; rose = 1'b0; fidx = 0; prev_scl = 1'b1; prev_sda_oe = 1'b0;
    end else begin
      if (scl_in && prev_scl && prev_sda_oe && !sda_oe) begin
        k = 0; rose = 1'b0; fidx = 0;
      end else begin
        if (scl_in && !prev_scl) begin
          rose = 1'b1;
          if (k == 8) begin
            frames_done++;
            chk(sda_oe == !ack_bit, "R5 ack level", int'(sda_oe), int'(!ack_bit));
          end else if (fidx < n_exp) begin
            chk(!sda_oe, "R3 SDA free on data bit", int'(sda_oe), 0);
          end
        end
        if (!scl_in && prev_scl && rose) begin
          rose = 1'b0;
          if (k == 8) begin k = 0; fidx++; end
          else k++;
        end
      end
      prev_scl = scl_in;
      prev_sda_oe = sda_oe;
    end
    sda_drv = (k < 8) ? sbytes[fidx % 4][7 - k] : 1'b1;
  end

  task automatic pulse_read();
    rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic pulse_last();
    last_req = 1'b1; @(negedge clk); last_req = 1'b0;
    chk(last_pend, "R9 last_pend set", int'(last_pend), 1);
  endtask

  task automatic wait_byte(input int idx);
    while (!(frames_done > idx && rx_full)) @(negedge clk);
  endtask

  task automatic finish_stop(input int base, input int n, input logic [7:0] last_b);
    while (!stop_done) @(negedge clk);
    chk(frames_done - base == n, "R9 frame count", frames_done - base, n);
    chk(!last_pend, "R10 last_pend cleared", int'(last_pend), 0);
    chk(rx_full, "R6 final byte full", int'(rx_full), 1);
    chk(rd_data == last_b, "R4 final byte", rd_data, last_b);
    pulse_read();
    chk(!rx_full, "R11 idle read clears", int'(rx_full), 0);
    repeat (4) @(negedge clk);
    chk(!scl_oe, "R11 idle read no start", int'(scl_oe), 0);
  endtask

  task automatic run_vec(input logic [23:0] v);
    int n, d, base, cnt, h;
    logic [7:0] seed;
    half_period = v[23:16]; seed = v[15:8]; n = int'(v[7:6]) + 1;
    ack_bit = v[5]; d = int'(v[4:0]) * 8; h = eff_half(int'(v[23:16]));
    for (int i = 0; i < 4; i++) sbytes[i] = exp_byte(seed, i);
    n_exp = n; base = frames_done;
    @(negedge clk);
    if (n == 1) pulse_last();
    pulse_read();
    cnt = 0; while (scl_oe) begin cnt++; @(negedge clk); end
    chk(cnt == h, "R2/R3 first low phase", cnt, h);
    cnt = 0; while (!scl_oe) begin cnt++; @(negedge clk); end
    chk(cnt == h, "R3 high phase", cnt, h);
    for (int i = 0; i < n - 1; i++) begin
      wait_byte(base + i);
      repeat (d) @(negedge clk);
      chk(!stop_done, "R8 no early stop", int'(stop_done), 0);
      if (i == n - 2) pulse_last();
      chk(rd_data == exp_byte(seed, i), "R4 byte", rd_data, exp_byte(seed, i));
      pulse_read();
    end
    finish_stop(base, n, exp_byte(seed, n - 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(!rx_full && !stop_done && !last_pend, "R1 flags", {rx_full, stop_done, last_pend}, 0);

    // R2 read in transmit mode is ignored
    xmit_sel = 1'b1;
    pulse_read();
    repeat (5) @(negedge clk);
    chk(!scl_oe && !stop_done, "R2 xmit_sel read ignored", int'(scl_oe), 0);
    xmit_sel = 1'b0;

    for (int vi = 0; vi < 5; vi++) run_vec(VEC[vi]);

    // R7 stall and R6 set/clear collision
    begin
      int base;
      half_period = 8'd3; ack_bit = 1'b0; n_exp = 2;
      for (int i = 0; i < 4; i++) sbytes[i] = exp_byte(8'h5A, i);
      base = frames_done;
      pulse_read();
      wait_byte(base);
      repeat (150) @(negedge clk);
      chk(scl_oe, "R7 SCL held low", int'(scl_oe), 1);
      chk(frames_done == base + 1, "R7 no ninth pulse", frames_done - base, 1);
      pulse_last();
      chk(rd_data == exp_byte(8'h5A, 0), "R4 stalled byte", rd_data, exp_byte(8'h5A, 0));
      pulse_read();
      chk(!scl_oe, "R7 released on read", int'(scl_oe), 0);
      chk(rx_full, "R6 set wins over clear", int'(rx_full), 1);
      chk(rd_data == exp_byte(8'h5A, 1), "R6 new byte loaded", rd_data, exp_byte(8'h5A, 1));
      finish_stop(base, 2, exp_byte(8'h5A, 1));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog act=hung exp=stop");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule